// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 18 address bits by 16 data bits. The host issues one single-word access at a time over a valid/ready handshake. Each access carries an address, write data, a two-bit lane mask and a direction flag. The controller turns the access into the chip-enable, byte-lane, write-strobe and output-enable levels the memory needs. It returns read data with a one-cycle valid pulse.

Every timing limit of the memory is given in nanoseconds as a parameter. Each one becomes a whole number of clock cycles: the requirement divided by the clock period, rounded up, and never less than one. Either speed grade can be selected this way. The data bus is split into an outgoing word, an incoming word and a drive-enable. The controller never drives the bus while the memory's outputs may still be active.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, `req_ready` is 1. The memory is then in standby: `sram_ce1_n`=1, `sram_ub_n`=1, `sram_lb_n`=1. The strobes are idle: `sram_we_n`=1, `sram_oe_n`=1. `sram_dq_oe`=0 and `sram_ce2`=1.
- R2: A write accepted on a clock edge (`req_valid`=1, `req_ready`=1, `req_write`=1) holds `sram_we_n` low for the write-strobe length. This length is the larger of the pulse-width count and the release count plus the data-setup count, which is 3 cycles at the defaults. One recovery cycle follows with `sram_we_n` high and the address unchanged. The controller is then idle again.
- R3: The write pulse lasts at least the pulse-width count of cycles (3 at the defaults). `sram_dq_oe` stays low for the first release-count cycles of the pulse. Write data is then held steady for at least the data-setup count of cycles (2 at the defaults) before `sram_we_n` rises.
- R4: The address does not change while `sram_we_n` is low. Address and write data are still held in the cycle after `sram_we_n` rises.
- R5: `sram_oe_n` is high whenever `sram_we_n` is low. The controller and the memory never drive the data bus in the same cycle.
- R6: A read drives `sram_ce1_n` low and `sram_oe_n` low for the access length. This is the largest of the address-access, output-enable-access and cycle counts, which is 3 at the defaults. `sram_dq_i` is captured at the end of the last access cycle. `rsp_valid` is high for exactly the following cycle. That cycle is also a turnaround with `sram_oe_n` high, lasting the release count (1 at the defaults) before `req_ready` returns.
- R7: Mask bit 1 enables the upper lane (bits 15..8, `sram_ub_n` low) and mask bit 0 enables the lower lane (bits 7..0, `sram_lb_n` low) during the access. Only enabled lanes of the memory are written. On a read, disabled lanes of `rsp_rdata` are 0.
- R8: An access with mask 00 keeps both lane enables high, so the memory stays deselected. Such a write leaves the stored word unchanged.
- R9: `req_ready` is low from the accepting edge until the access, including recovery or turnaround, completes. At the defaults this is 4 cycles for both a write and a read. Requests are accepted only while `req_ready` is 1.
- R10: Back-to-back writes with `req_valid` held high always have `sram_we_n` high before the address changes to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_i | input | 16 | Data from memory bus |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_ce1_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_ub_n | output | 1 | Active-low upper lane enable |
| sram_lb_n | output | 1 | Active-low lower lane enable |

## Verification
Some properties are checked on every cycle by the assertions:
- output enable is never low under an active write strobe;
- the controller never drives the bus while output enable is low;
- the address holds through the strobe and one cycle beyond;
- write data stays steady while driven;
- the read strobe lasts one cycle;
- lanes stay disabled while idle.

Other behaviour needs the bench's memory model and scenarios. The model returns garbage until the access time has elapsed and keeps driving for a cycle after output enable rises, so it can show whether capture happens late enough and whether the turnaround cycle is really there. It also measures pulse width and data setup at each strobe's rising edge. Only full write-then-read sequences can show that lane masking and mask-00 accesses leave the memory contents as expected.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int CLK_NS      = 20,
  parameter int T_CYCLE_NS  = 55,
  parameter int T_WPULSE_NS = 45,
  parameter int T_DSETUP_NS = 25,
  parameter int T_ACCESS_NS = 55,
  parameter int T_OEACC_NS  = 25,
  parameter int T_OEREL_NS  = 20,
  parameter int T_WEREL_NS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic          sram_ub_n,
  output logic          sram_lb_n
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CYC_C  = to_cyc(T_CYCLE_NS);
  localparam int WP_C   = to_cyc(T_WPULSE_NS);
  localparam int DS_C   = to_cyc(T_DSETUP_NS);
  localparam int AA_C   = to_cyc(T_ACCESS_NS);
  localparam int OA_C   = to_cyc(T_OEACC_NS);
  localparam int HZ_C   = to_cyc(T_OEREL_NS);
  localparam int WLZ_C  = to_cyc(T_WEREL_NS);
  localparam int W_LEN  = max2(WP_C, WLZ_C + DS_C);
  localparam int REC_LEN = max2(1, CYC_C - W_LEN);
  localparam int R_LEN  = max2(max2(AA_C, OA_C), CYC_C);
  localparam int CW     = $clog2(max2(max2(W_LEN, R_LEN), max2(REC_LEN, HZ_C)) + 1);
  localparam logic [CW-1:0] W_END  = CW'(W_LEN - 1);
  localparam logic [CW-1:0] RC_END = CW'(REC_LEN - 1);
  localparam logic [CW-1:0] R_END  = CW'(R_LEN - 1);
  localparam logic [CW-1:0] T_END  = CW'(HZ_C - 1);
  localparam logic [CW-1:0] DRV_AT = CW'(WLZ_C);

  typedef enum logic [2:0] {S_IDLE, S_WSTB, S_WREC, S_RACC, S_RTURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    mask_q;
  logic          active;

  assign req_ready  = (st == S_IDLE);
  assign active     = (st == S_WSTB) || (st == S_WREC) || (st == S_RACC);
  assign sram_addr  = addr_q;
  assign sram_dq_o  = wdata_q;
  assign sram_ce1_n = !active;
  assign sram_ce2   = 1'b1;
  assign sram_ub_n  = !(active && mask_q[1]);
  assign sram_lb_n  = !(active && mask_q[0]);
  assign sram_we_n  = (st != S_WSTB);
  assign sram_oe_n  = (st != S_RACC);
  assign sram_dq_oe = ((st == S_WSTB) && (cnt >= DRV_AT)) || (st == S_WREC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            st      <= req_write ? S_WSTB : S_RACC;
          end
        end
        S_WSTB: begin
          if (cnt == W_END) begin st <= S_WREC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_WREC: begin
          if (cnt == RC_END) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_RACC: begin
          if (cnt == R_END) begin
            st        <= S_RTURN;
            cnt       <= '0;
            rsp_valid <= 1'b1;
            rsp_rdata <= sram_dq_i & {{(DW/2){mask_q[1]}}, {(DW/2){mask_q[0]}}};
          end else cnt <= cnt + 1'b1;
        end
        S_RTURN: begin
          if (cnt == T_END) begin st <= S_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> $stable(sram_addr));

  a_r3_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |=> (!sram_dq_oe || $stable(sram_dq_o)));

  a_r6_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce1_n && sram_ub_n && sram_lb_n && sram_we_n && sram_oe_n));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int W_STB = 3, W_REC = 1, R_ACC = 3, R_TA = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata, sram_dq_o, dq_bus;
  logic [17:0] sram_addr;
  logic sram_dq_oe, sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  asram_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_i(dq_bus), .sram_dq_oe(sram_dq_oe),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural memory model
  logic [15:0] mem [int];
  int   rd_cnt = 0, hold_cnt = 0, wl_cnt = 0, ds_cnt = 0;
  logic [15:0] m_word = '0, w_data = '0;
  logic [17:0] w_addr = '0;
  logic rd_active, m_drv;
  logic [15:0] m_data;

  assign rd_active = !sram_ce1_n && sram_ce2 && sram_we_n && !sram_oe_n && (!sram_ub_n || !sram_lb_n);
  assign m_drv  = rd_active || (hold_cnt > 0);
  assign m_data = (rd_cnt >= R_ACC) ?
                  {(!sram_ub_n ? m_word[15:8] : 8'hA5), (!sram_lb_n ? m_word[7:0] : 8'h5A)} : 16'hDEAD;
  assign dq_bus = sram_dq_oe ? sram_dq_o : (m_drv ? m_data : 16'hzzzz);

  always @(negedge clk) if (rst_n) begin
    logic wr_now;
    if (sram_dq_oe && m_drv) chk(0, "R5 bus contention", 32'(sram_dq_o), 32'(m_data));
    if (rd_active) begin
      rd_cnt++;
      hold_cnt = 1;
      m_word = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
    end else begin
      rd_cnt = 0;
      if (hold_cnt > 0) hold_cnt--;
    end
    wr_now = !sram_ce1_n && sram_ce2 && !sram_we_n;
    if (wr_now) begin
      if (wl_cnt > 0 && sram_addr != w_addr)
        chk(0, "R4 address moved under write strobe", 32'(sram_addr), 32'(w_addr));
      wl_cnt++;
      w_addr = sram_addr;
      if (sram_dq_oe) begin
        if (ds_cnt > 0 && sram_dq_o == w_data) ds_cnt++; else ds_cnt = 1;
        w_data = sram_dq_o;
      end else ds_cnt = 0;
    end else if (wl_cnt > 0) begin
      logic [15:0] v;
      chk(wl_cnt >= W_STB, "R3 write pulse width", 32'(wl_cnt), 32'(W_STB));
      chk(ds_cnt >= 2, "R3 data setup cycles", 32'(ds_cnt), 32'd2);
      chk(sram_addr == w_addr && sram_dq_oe && sram_dq_o == w_data, "R4 hold after strobe",
          {sram_dq_oe, 13'd0, sram_addr}, {1'b1, 13'd0, w_addr});
      v = mem.exists(int'(w_addr)) ? mem[int'(w_addr)] : 16'h0000;
      if (!sram_ub_n) v[15:8] = w_data[15:8];
      if (!sram_lb_n) v[7:0]  = w_data[7:0];
      mem[int'(w_addr)] = v;
      wl_cnt = 0;
      ds_cnt = 0;
    end
  end

  // cycle reference model
  logic [15:0] exp_mem [int];
  logic inflight = 0, is_rd = 0, is_wr_ref = 0;
  int   age = 0;
  logic [1:0]  r_mask = '0;
  logic [15:0] exp_rd = '0;
  logic exp_ready;
  assign exp_ready = !inflight;

  always @(posedge clk) begin
    if (!rst_n) begin
      inflight <= 0; age <= 0;
    end else if (!inflight && req_valid) begin
      logic [15:0] v;
      v = exp_mem.exists(int'(req_addr)) ? exp_mem[int'(req_addr)] : 16'h0000;
      inflight  <= 1;
      age       <= 0;
      is_rd     <= !req_write;
      is_wr_ref <= req_write;
      r_mask    <= req_mask;
      if (req_write) begin
        if (req_mask[1]) v[15:8] = req_wdata[15:8];
        if (req_mask[0]) v[7:0]  = req_wdata[7:0];
        exp_mem[int'(req_addr)] = v;
      end else
        exp_rd <= v & {{8{req_mask[1]}}, {8{req_mask[0]}}};
    end else if (inflight) begin
      if (age == (is_rd ? R_ACC + R_TA - 1 : W_STB + W_REC - 1)) inflight <= 0;
      else age <= age + 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic ersp;
    ersp = inflight && is_rd && age == R_ACC;
    chk(req_ready == exp_ready, "R9 ready", 32'(req_ready), 32'(exp_ready));
    chk(rsp_valid == ersp, "R6 rsp_valid", 32'(rsp_valid), 32'(ersp));
    if (ersp) chk(rsp_rdata == exp_rd, "R7 read data", 32'(rsp_rdata), 32'(exp_rd));
    if (exp_ready)
      chk(sram_ce1_n && sram_ub_n && sram_lb_n && sram_we_n && sram_oe_n && !sram_dq_oe && sram_ce2,
          "R1 idle standby", {sram_ce1_n, sram_ub_n, sram_lb_n, sram_we_n, sram_oe_n, sram_dq_oe}, 6'b111110);
    else begin
      logic ewe, eoe;
      ewe = !(is_wr_ref && age < W_STB);
      eoe = !(is_rd && age < R_ACC);
      chk(sram_we_n == ewe, "R2 write strobe", 32'(sram_we_n), 32'(ewe));
      chk(sram_oe_n == eoe, "R6 output enable", 32'(sram_oe_n), 32'(eoe));
      if (is_wr_ref && age == 0) chk(!sram_dq_oe, "R3 driver off during release", 32'(sram_dq_oe), 0);
      if (is_wr_ref || age < R_ACC)
        chk(sram_ub_n == !r_mask[1] && sram_lb_n == !r_mask[0] && !sram_ce1_n,
            "R7 R8 lane enables", {sram_ce1_n, sram_ub_n, sram_lb_n}, {1'b0, !r_mask[1], !r_mask[0]});
      else
        chk(sram_ce1_n, "R6 turnaround deselect", 32'(sram_ce1_n), 1);
    end
  end

  task automatic issue(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    logic rdy;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && sram_ce1_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n && !sram_dq_oe,
        "R1 reset state", {req_ready, sram_ce1_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe}, 7'b1111110);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2 R3 full word write then read
    issue(1, 18'h00123, 16'hBEEF, 2'b11); settle();
    issue(0, 18'h00123, 16'h0000, 2'b11); settle();
    // R7 lower lane only write, then read whole word
    issue(1, 18'h00123, 16'h1234, 2'b01); settle();
    issue(0, 18'h00123, 16'h0000, 2'b11); settle();
    // R7 upper lane only write
    issue(1, 18'h00123, 16'h9900, 2'b10); settle();
    issue(0, 18'h00123, 16'h0000, 2'b11); settle();
    // R7 read with one lane disabled returns zero there
    issue(0, 18'h00123, 16'h0000, 2'b01); settle();
    issue(0, 18'h00123, 16'h0000, 2'b10); settle();
    // R8 mask 00 write leaves memory unchanged
    issue(1, 18'h00123, 16'h0F0F, 2'b00); settle();
    issue(0, 18'h00123, 16'h0000, 2'b11); settle();
    // R10 back-to-back writes, address extremes
    issue(1, 18'h00000, 16'hA001, 2'b11);
    issue(1, 18'h3FFFF, 16'hA002, 2'b11);
    issue(1, 18'h15555, 16'hA003, 2'b11);
    issue(1, 18'h2AAAA, 16'hA004, 2'b11);
    // back-to-back reads right after writes
    issue(0, 18'h00000, 16'h0000, 2'b11);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    issue(0, 18'h15555, 16'h0000, 2'b11);
    issue(0, 18'h2AAAA, 16'h0000, 2'b11);
    issue(0, 18'h00777, 16'h0000, 2'b11);
    settle();
    // R9 alternating write/read stream
    for (int i = 0; i < 20; i++) begin
      issue(1, 18'(i * 37), 16'(i * 16'h0111), 2'(i % 4));
      issue(0, 18'(i * 37), 16'h0000, 2'b11);
    end
    settle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule